// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds a set of identical 32-bit register copies, one per hardware unit, that all answer at a single bus address. A second address holds a steering selector with a group field, an instance field and a broadcast flag. When the flag is set, a write to the shared address lands in every live copy at once. When it is clear, the write lands only in the one copy that the selector points at. Reads of the shared address never broadcast. They always return the single copy named by the selector, whatever the flag says.

Each copy has an enable input. A low enable marks a copy that is fused off or power-gated, and such a copy is called terminated. A read steered to a terminated copy returns zero. A targeted write steered to one is dropped without any error. A broadcast write skips it. Copies are numbered group × INST_PER_GROUP + instance. A selector value that names a group or instance outside the built range counts as terminated. The bus is a plain strobe interface, and read data comes from a register one cycle after the read strobe.

Top module: `repl_steer_bank`

## Requirements
- R1: After reset, the selector holds broadcast mode with group 0 and instance 0, every copy holds zero, and the read data output is zero.
- R2: A write to the shared address with the broadcast flag set stores the write data in every copy whose enable is high.
- R3: A broadcast write leaves every copy whose enable is low at its previous value.
- R4: A write to the shared address with the broadcast flag clear changes only the copy at index group × INST_PER_GROUP + instance. All other copies keep their values.
- R5: A targeted write whose steered copy has its enable low changes no copy.
- R6: A group value of NUM_GROUPS or more, or an instance value of INST_PER_GROUP or more, is treated as terminated. Reads of the shared address return zero and targeted writes change no copy.
- R7: A read of the shared address returns the steered copy whether the broadcast flag is set or clear.
- R8: A read of the shared address steered to a copy whose enable is low returns zero.
- R9: Read data is registered. It shows the value chosen on the cycle of the read strobe from the next clock edge on, and it holds its value while no read strobe is given.
- R10: The selector is written and read at its own address with this layout: instance in bits 3:0, group in bits 7:4, broadcast flag in bit 31. All other bits read as zero.
- R11: A write to any address other than the two mapped ones changes nothing, and a read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Bus address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| inst_en | input | 16 | Per-copy live flag (low = terminated) |

## Verification
The bench builds the block with the defaults: 4 groups, 4 instances per group and 4-bit selector fields. Because the fields are wider than the built range, selector values from 4 to 15 in either field can be written. Group 0 with instance 4 would alias copy 4 under plain index arithmetic, so the bench uses it to expose any missing range check. With 16 enables under direct control, the bench can terminate a single copy between a broadcast write and a later read of that same copy.

// File: rtl/repl_steer_pkg.sv
package repl_steer_pkg;
  localparam int SEL_FLD_W = 4;
  localparam int BCAST_BIT = 31;

  typedef struct packed {
    logic                 bcast;
    logic [SEL_FLD_W-1:0] grp;
    logic [SEL_FLD_W-1:0] ins;
  } steer_sel_t;

  function automatic steer_sel_t sel_from_word(input logic [31:0] w);
    steer_sel_t s;
    s.bcast = w[BCAST_BIT];
    s.grp   = w[2*SEL_FLD_W-1:SEL_FLD_W];
    s.ins   = w[SEL_FLD_W-1:0];
    return s;
  endfunction

  function automatic logic [31:0] sel_to_word(input steer_sel_t s);
    logic [31:0] w;
    w = '0;
    w[BCAST_BIT] = s.bcast;
    w[2*SEL_FLD_W-1:SEL_FLD_W] = s.grp;
    w[SEL_FLD_W-1:0] = s.ins;
    return w;
  endfunction
endpackage

// File: rtl/rsb_steer_sel.sv
module rsb_steer_sel
  import repl_steer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_we,
  input  logic [31:0] sel_wdata,
  output steer_sel_t  sel_q
);
  steer_sel_t sel_d;

  always_comb begin
    sel_d = sel_q;
    if (sel_we) sel_d = sel_from_word(sel_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q.bcast <= 1'b1;
      sel_q.grp   <= '0;
      sel_q.ins   <= '0;
    end else if (sel_we) begin
      sel_q <= sel_d;
    end
  end
endmodule

// File: rtl/rsb_steer_decode.sv
module rsb_steer_decode
  import repl_steer_pkg::*;
#(
  parameter int NUM_GROUPS     = 4,
  parameter int INST_PER_GROUP = 4,
  localparam int NUM_COPIES    = NUM_GROUPS * INST_PER_GROUP
) (
  input  steer_sel_t              sel,
  input  logic [NUM_COPIES-1:0]   inst_en,
  output logic [NUM_COPIES-1:0]   tgt_oh,
  output logic                    tgt_live
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar i = 0; i < INST_PER_GROUP; i++) begin : g_ins
      localparam int K = g * INST_PER_GROUP + i;
      logic hit;
      assign hit       = (sel.grp == SEL_FLD_W'(g)) && (sel.ins == SEL_FLD_W'(i));
      assign tgt_oh[K] = hit & inst_en[K];
    end
  end

  assign tgt_live = |tgt_oh;
endmodule

// File: rtl/rsb_copy_slice.sv
module rsb_copy_slice #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] d;

  always_comb begin
    d = q;
    if (wr_hit) d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (wr_hit) q <= d;
  end
endmodule

// File: rtl/repl_steer_bank.sv
module repl_steer_bank
  import repl_steer_pkg::*;
#(
  parameter int          DATA_W         = 32,
  parameter int          ADDR_W         = 8,
  parameter int          NUM_GROUPS     = 4,
  parameter int          INST_PER_GROUP = 4,
  parameter logic [7:0]  REPL_ADDR      = 8'h10,
  parameter logic [7:0]  SEL_ADDR       = 8'h14,
  localparam int         NUM_COPIES     = NUM_GROUPS * INST_PER_GROUP
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic                  bus_re,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NUM_COPIES-1:0] inst_en
);
  steer_sel_t              sel_q;
  logic [NUM_COPIES-1:0]   tgt_oh;
  logic                    tgt_live;
  logic                    repl_hit, sel_hit;
  logic                    repl_wr, sel_wr;
  logic [NUM_COPIES*DATA_W-1:0] copies_flat;
  logic [DATA_W-1:0]       steered_val;
  logic [DATA_W-1:0]       rdata_d;
  logic [31:0]             sel_word;

  assign repl_hit = (bus_addr == ADDR_W'(REPL_ADDR));
  assign sel_hit  = (bus_addr == ADDR_W'(SEL_ADDR));
  assign repl_wr  = bus_we & repl_hit;
  assign sel_wr   = bus_we & sel_hit;

  rsb_steer_sel u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_we    (sel_wr),
    .sel_wdata (32'(bus_wdata)),
    .sel_q     (sel_q)
  );

  rsb_steer_decode #(
    .NUM_GROUPS     (NUM_GROUPS),
    .INST_PER_GROUP (INST_PER_GROUP)
  ) u_dec (
    .sel      (sel_q),
    .inst_en  (inst_en),
    .tgt_oh   (tgt_oh),
    .tgt_live (tgt_live)
  );

  for (genvar k = 0; k < NUM_COPIES; k++) begin : g_copy
    logic hit_k;
    assign hit_k = repl_wr & inst_en[k] & (sel_q.bcast | tgt_oh[k]);
    rsb_copy_slice #(.DATA_W(DATA_W)) u_slice (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (hit_k),
      .wdata  (bus_wdata),
      .q      (copies_flat[k*DATA_W +: DATA_W])
    );
  end

  always_comb begin
    steered_val = '0;
    for (int k = 0; k < NUM_COPIES; k++) begin
      steered_val |= copies_flat[k*DATA_W +: DATA_W] & {DATA_W{tgt_oh[k]}};
    end
  end

  assign sel_word = sel_to_word(sel_q);

  always_comb begin
    rdata_d = '0;
    if (repl_hit)     rdata_d = tgt_live ? steered_val : '0;
    else if (sel_hit) rdata_d = DATA_W'(sel_word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rdata_d;
  end
endmodule

// File: rtl/repl_steer_bank_chk.sv
module repl_steer_bank_chk
  import repl_steer_pkg::*;
#(
  parameter int         DATA_W     = 32,
  parameter int         ADDR_W     = 8,
  parameter int         NUM_COPIES = 16,
  parameter logic [7:0] REPL_ADDR  = 8'h10,
  parameter logic [7:0] SEL_ADDR   = 8'h14
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic                         bus_we,
  input logic                         bus_re,
  input logic [DATA_W-1:0]            bus_wdata,
  input logic [DATA_W-1:0]            bus_rdata,
  input logic [NUM_COPIES-1:0]        inst_en,
  input logic                         sel_bcast,
  input logic [NUM_COPIES*DATA_W-1:0] copies_flat
);
  logic [NUM_COPIES*DATA_W-1:0] prev_flat;
  logic [NUM_COPIES*DATA_W-1:0] en_wide;
  logic [NUM_COPIES-1:0]        chg;
  logic                         repl_wr, unmapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_flat <= '0;
    else        prev_flat <= copies_flat;
  end

  for (genvar k = 0; k < NUM_COPIES; k++) begin : g_w
    assign en_wide[k*DATA_W +: DATA_W] = {DATA_W{inst_en[k]}};
    assign chg[k] = copies_flat[k*DATA_W +: DATA_W] != prev_flat[k*DATA_W +: DATA_W];
  end

  assign repl_wr  = bus_we && bus_addr == ADDR_W'(REPL_ADDR);
  assign unmapped = bus_addr != ADDR_W'(REPL_ADDR) && bus_addr != ADDR_W'(SEL_ADDR);

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

  a_r11_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && unmapped) |=> bus_rdata == '0);

  a_r10_sel_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == ADDR_W'(SEL_ADDR)) |=> bus_rdata[BCAST_BIT-1:2*SEL_FLD_W] == '0);

  a_r3_terminated_kept: assert property (@(posedge clk) disable iff (!rst_n)
    repl_wr |=> ((copies_flat ^ prev_flat) & ~$past(en_wide)) == '0);

  a_r2_bcast_fills_live: assert property (@(posedge clk) disable iff (!rst_n)
    (repl_wr && sel_bcast) |=>
      ((copies_flat ^ {NUM_COPIES{$past(bus_wdata)}}) & $past(en_wide)) == '0);

  a_r4_unicast_single: assert property (@(posedge clk) disable iff (!rst_n)
    (repl_wr && !sel_bcast) |=> $onehot0(chg));

  a_r11_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !repl_wr |=> chg == '0);
endmodule

bind repl_steer_bank repl_steer_bank_chk #(
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W),
  .NUM_COPIES (NUM_COPIES),
  .REPL_ADDR  (REPL_ADDR),
  .SEL_ADDR   (SEL_ADDR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_re      (bus_re),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .inst_en     (inst_en),
  .sel_bcast   (sel_q.bcast),
  .copies_flat (copies_flat)
);

// File: tb/repl_steer_bank_tb.sv
module repl_steer_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NG  = 4;
  localparam int IPG = 4;
  localparam int NC  = NG * IPG;
  localparam logic [7:0] A_REPL = 8'h10;
  localparam logic [7:0] A_SEL  = 8'h14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    bus_addr;
  logic          bus_we, bus_re;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] inst_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  repl_steer_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .inst_en(inst_en)
  );

  // Behavioural reference model
  logic [31:0] m_copy [NC];
  bit          m_bc;
  int          m_g, m_i;
  logic [31:0] m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_copy[k]) m_copy[k] = 32'h0;
      m_bc = 1; m_g = 0; m_i = 0; m_rd = 32'h0;
    end else begin
      int t;
      bit live;
      t = (m_g < NG && m_i < IPG) ? m_g * IPG + m_i : -1;
      live = (t >= 0) && inst_en[t];
      if (bus_re) begin
        if (bus_addr == A_REPL)     m_rd = live ? m_copy[t] : 32'h0;
        else if (bus_addr == A_SEL) m_rd = {m_bc, 23'h0, 4'(m_g), 4'(m_i)};
        else                        m_rd = 32'h0;
      end
      if (bus_we) begin
        if (bus_addr == A_SEL) begin
          m_bc = bus_wdata[31]; m_g = int'(bus_wdata[7:4]); m_i = int'(bus_wdata[3:0]);
        end else if (bus_addr == A_REPL) begin
          for (int k = 0; k < NC; k++)
            if (inst_en[k] && (m_bc || k == t)) m_copy[k] = bus_wdata;
        end
      end
    end
  end

  // R9: registered read data compared with the model on every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (bus_rdata !== m_rd) begin
        errors++;
        $display("FAIL R9 model compare: actual %h expected %h", bus_rdata, m_rd);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; bus_re = 1'b1; bus_we = 1'b0;
    @(negedge clk);
    bus_re = 1'b0;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = 8'h0; bus_we = 1'b0; bus_re = 1'b0;
    bus_wdata = 32'h0; inst_en = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    rd(A_SEL, 32'h8000_0000, "R1 R10 selector reset value");
    rd(A_REPL, 32'h0, "R1 copy reset value");

    wr(A_REPL, 32'h1111_1111);
    wr(A_SEL, 32'h0000_0023);               // group 2, instance 3, unicast -> copy 11
    rd(A_SEL, 32'h0000_0023, "R10 selector readback");
    rd(A_REPL, 32'h1111_1111, "R2 broadcast reached copy 11");
    wr(A_REPL, 32'hDEAD_0011);
    rd(A_REPL, 32'hDEAD_0011, "R4 unicast write to copy 11");
    wr(A_SEL, 32'h0000_0022);
    rd(A_REPL, 32'h1111_1111, "R4 neighbour copy 10 untouched");

    wr(A_SEL, 32'h8000_0023);
    rd(A_REPL, 32'hDEAD_0011, "R7 read unicast under broadcast flag");

    inst_en[11] = 1'b0;
    rd(A_REPL, 32'h0, "R8 terminated copy reads zero");
    wr(A_REPL, 32'h2222_2222);
    inst_en[11] = 1'b1;
    rd(A_REPL, 32'hDEAD_0011, "R3 terminated copy kept on broadcast");
    wr(A_SEL, 32'h8000_0000);
    rd(A_REPL, 32'h2222_2222, "R2 broadcast reached copy 0");

    inst_en[5] = 1'b0;
    wr(A_SEL, 32'h0000_0011);                // copy 5
    wr(A_REPL, 32'h5555_5555);
    inst_en[5] = 1'b1;
    rd(A_REPL, 32'h2222_2222, "R5 unicast to terminated copy dropped");

    wr(A_SEL, 32'h0000_0050);                // group 5 out of range
    rd(A_REPL, 32'h0, "R6 group out of range reads zero");
    wr(A_REPL, 32'h6666_6666);
    wr(A_SEL, 32'h0000_0004);                // instance 4 out of range
    rd(A_REPL, 32'h0, "R6 instance out of range reads zero");
    wr(A_REPL, 32'h7777_7777);
    wr(A_SEL, 32'h0000_0010);                // copy 4, alias target
    rd(A_REPL, 32'h2222_2222, "R6 out of range writes dropped (copy 4)");
    wr(A_SEL, 32'h0000_0000);
    rd(A_REPL, 32'h2222_2222, "R6 out of range writes dropped (copy 0)");

    wr(8'h20, 32'h9999_9999);
    rd(8'h20, 32'h0, "R11 unmapped read zero");
    rd(A_REPL, 32'h2222_2222, "R11 unmapped write no effect");

    rd(A_SEL, 32'h0000_0000, "R10 selector value");
    repeat (3) @(negedge clk);
    check("R9 rdata held without strobe", bus_rdata, 32'h0);
    rd(A_REPL, 32'h2222_2222, "R9 read registered");
    bus_addr = A_SEL;
    repeat (2) @(negedge clk);
    check("R9 rdata held after address change", bus_rdata, 32'h2222_2222);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule